// File: doc/BRIEF.md
# Paged register window decoder

This block connects a 32-bit memory-mapped slave port, whose address covers only 4 KB, to an internal control and status register space of up to 64 KB. Bus addresses in the low part of the aperture reach the internal register with the same offset. The top 1 KB of the bus aperture, from 0xC00 to 0xFFF, is a movable window. A page field in a control register selects which 1 KB slice of the internal space that window shows. Software therefore reaches any internal register with a single bus access after it has programmed the page.

Each request carries a byte count of 1, 2 or 4. The block checks the size and the alignment of every request. It steers write data onto the addressed byte lanes of the target 32-bit register. Read data comes back right-justified. The block holds the internal register file as a RAM of 32-bit words, plus the control register that holds the page field and two programmed-I/O enable bits. Each accepted request receives one response on the following cycle. A rejected request returns an error flag with zero data.

Top module: `pgwin_decoder`

## Requirements
- R1: A request with a bus address below 0xC00 reaches the internal register at the same offset, whatever the value of the page field.
- R2: The page field is bits 18:13 of the control register. The control register sits at internal offset 0x808, which is reached directly at bus address 0x808 and also through the window at 0xC08 when the page is 2. Reading it returns its full 32-bit contents.
- R3: A request with a bus address from 0xC00 to 0xFFF reaches internal offset page × 1024 + (address − 0xC00). The page is the field value at the time the request is accepted, so a page written in one cycle applies to a request accepted in the next cycle.
- R4: The size input is a byte count. Only 1, 2 and 4 are legal, and any other value (0, 3, 5, 6, 7) is rejected.
- R5: A request is rejected when its size is 2 and address bit 0 is set, or when its size is 4 and address bits 1:0 are not zero.
- R6: A rejected request responds with the error flag high together with the response valid flag for that one response, and with read data zero. It modifies neither the register file nor the control register.
- R7: Write data is taken right-justified and goes to byte lane (address bits 1:0) upward. A byte or halfword write changes only its own lanes. Read data returns right-justified and is zero-extended above the access size.
- R8: Control register bits 1:0 drive the two programmed-I/O enable outputs. A write that does not cover byte 0 of the control register leaves them unchanged. Such writes include a byte write to 0x809 and a halfword write to 0x80A.
- R9: The request ready output is high from the first cycle after reset. Every accepted request produces exactly one response, on the cycle after it is accepted. There is no response in any cycle that does not follow an accepted request.
- R10: Internal word addresses at or above the register file depth (NUM_WORDS words, 1024 by default, so internal offsets from 0x1000) read as zero. Writes to them are dropped without an error response and alter no backed register.
- R11: After reset the control register is zero, the enable outputs are 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Bus byte address |
| req_size | input | 3 | Access size as a byte count (1, 2 or 4 legal) |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Right-justified read data, zero on writes and errors |
| pio_en | output | 2 | Programmed-I/O enables from control register bits 1:0 |

## Verification
Each result arrives exactly one cycle after the rising edge that accepts its request. This holds for the response flags, the read data, and the enable outputs after a control register write. A page written by a control register write applies to the very next accepted request. The bench drives each request on a falling edge and samples the response on the next falling edge, just after the accepting edge. A dedicated scenario issues a page write and a windowed read in consecutive cycles, then checks that the response valid flag drops in the idle cycle that follows.

// File: rtl/pgwin_pkg.sv
// Package: geometry constants and the translation result type shared by the
// paged register window decoder and its sub-blocks.
package pgwin_pkg;
    localparam int BUS_AW     = 12;      // bus byte address width (4 KB aperture)
    localparam int WIN_AW     = 10;      // windowed slice width (1 KB)
    localparam int PAGE_W     = 6;       // page field width
    localparam int INT_AW     = PAGE_W + WIN_AW;  // internal byte address width
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam logic [BUS_AW-1:0] WIN_BASE = 12'hC00;
    localparam logic [INT_AW-1:0] CTRL_OFF = 16'h0808;
    localparam int PAGE_LSB   = 13;      // page field position in the control register

    typedef struct packed {
        logic               ok;        // legal size and alignment
        logic [INT_AW-1:0]  iaddr;     // internal byte address
        logic [BE_W-1:0]    be;        // byte lane enables
        logic [DATA_W-1:0]  wlane;     // write data moved onto its lanes
        logic [1:0]         shift;     // lane of the lowest byte
        logic               is_ctrl;   // targets the control register
    } xlate_t;
endpackage

// File: rtl/pgwin_xlate.sv
// Module: pgwin_xlate
// Combinational translation of one bus request. Folds the upper 1 KB of the
// bus aperture into the page selected by the caller, checks size and
// alignment and builds lane enables. Assumes size is a byte count.
module pgwin_xlate
    import pgwin_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PAGE_W-1:0] page,
    output xlate_t            xo
);
    localparam logic [INT_AW-3:0] CTRL_WORD = CTRL_OFF[INT_AW-1:2];

    logic size_ok;
    logic align_ok;
    logic in_window;

    // Legality of size and alignment.
    always_comb begin
        size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        unique case (size)
            3'd2:    align_ok = ~addr[0];
            3'd4:    align_ok = (addr[1:0] == 2'b00);
            default: align_ok = 1'b1;
        endcase
    end

    // Address folding, lane enables and lane placement of write data.
    always_comb begin
        in_window = (addr >= WIN_BASE);
        xo.ok     = size_ok && align_ok;
        xo.shift  = addr[1:0];
        if (in_window)
            xo.iaddr = {page, addr[WIN_AW-1:0]};
        else
            xo.iaddr = {{(INT_AW-BUS_AW){1'b0}}, addr};
        unique case (size)
            3'd1:    xo.be = 4'b0001 << addr[1:0];
            3'd2:    xo.be = 4'b0011 << addr[1:0];
            default: xo.be = 4'b1111;
        endcase
        xo.wlane   = wdata << {addr[1:0], 3'b000};
        xo.is_ctrl = (xo.iaddr[INT_AW-1:2] == CTRL_WORD);
    end
endmodule

// File: rtl/pgwin_regfile.sv
// Module: pgwin_regfile
// Word-wide register RAM with byte-lane writes and a registered read port.
// Words at or above NUM_WORDS are not backed: reads give zero, writes drop.
// Assumes at most one access per cycle.
module pgwin_regfile #(
    parameter int IDX_W     = 14,
    parameter int NUM_WORDS = 1024,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int MEM_AW = $clog2(NUM_WORDS);
    localparam int LANES  = DATA_W / 8;

    logic [DATA_W-1:0] mem [NUM_WORDS];
    logic              hit;
    logic [MEM_AW-1:0] widx;

    // Backed-word decode.
    always_comb begin
        hit  = (32'(idx) < NUM_WORDS);
        widx = idx[MEM_AW-1:0];
    end

    // Byte-lane write into the RAM.
    always_ff @(posedge clk) begin
        if (en && we && hit) begin
            for (int b = 0; b < LANES; b++) begin
                if (be[b]) mem[widx][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // Registered read, zero for unbacked words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (en && !we)
            rdata <= hit ? mem[widx] : '0;
    end
endmodule

// File: rtl/pgwin_decoder.sv
// Module: pgwin_decoder (top)
// Paged register window decoder. Accepts one request per cycle, translates
// it, applies it to the control register or the register file and responds
// on the next cycle. Assumes a 12-bit bus byte address and byte-count sizes.
module pgwin_decoder
    import pgwin_pkg::*;
#(
    parameter int NUM_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [1:0]        pio_en
);
    localparam int IDX_W = INT_AW - 2;

    xlate_t            xo;
    logic              acc;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ctrl_rd_q;
    logic [DATA_W-1:0] rf_rdata;
    logic              rf_en;
    logic              ready_q;
    logic              rsp_v_q;
    logic              rsp_e_q;
    logic              rd_ok_q;
    logic              rd_ctrl_q;
    logic [1:0]        rd_shift_q;
    logic [2:0]        rd_size_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_shaped;

    pgwin_xlate u_xlate (
        .addr  (req_addr),
        .size  (req_size),
        .wdata (req_wdata),
        .page  (ctrl_q[PAGE_LSB +: PAGE_W]),
        .xo    (xo)
    );

    // Request acceptance and register file enable.
    always_comb begin
        acc   = req_valid && ready_q;
        rf_en = acc && xo.ok && !xo.is_ctrl;
    end

    pgwin_regfile #(
        .IDX_W     (IDX_W),
        .NUM_WORDS (NUM_WORDS),
        .DATA_W    (DATA_W)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rf_en),
        .we    (req_write),
        .idx   (xo.iaddr[INT_AW-1:2]),
        .be    (xo.be),
        .wdata (xo.wlane),
        .rdata (rf_rdata)
    );

    // Ready comes up one cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Control register: byte-lane writes from legal accesses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (acc && req_write && xo.ok && xo.is_ctrl) begin
            for (int b = 0; b < BE_W; b++) begin
                if (xo.be[b]) ctrl_q[b*8 +: 8] <= xo.wlane[b*8 +: 8];
            end
        end
    end

    // Response state captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_v_q    <= 1'b0;
            rsp_e_q    <= 1'b0;
            rd_ok_q    <= 1'b0;
            rd_ctrl_q  <= 1'b0;
            rd_shift_q <= '0;
            rd_size_q  <= '0;
            ctrl_rd_q  <= '0;
        end else begin
            rsp_v_q    <= acc;
            rsp_e_q    <= acc && !xo.ok;
            rd_ok_q    <= acc && !req_write && xo.ok;
            rd_ctrl_q  <= xo.is_ctrl;
            rd_shift_q <= xo.shift;
            rd_size_q  <= req_size;
            ctrl_rd_q  <= ctrl_q;
        end
    end

    // Read data: select source, move down from its lane, zero-extend.
    always_comb begin
        rd_word   = rd_ctrl_q ? ctrl_rd_q : rf_rdata;
        rd_shaped = rd_word >> {rd_shift_q, 3'b000};
        unique case (rd_size_q)
            3'd1:    rd_shaped = rd_shaped & 32'h0000_00FF;
            3'd2:    rd_shaped = rd_shaped & 32'h0000_FFFF;
            default: rd_shaped = rd_shaped;
        endcase
    end

    // Output drive.
    always_comb begin
        req_ready = ready_q;
        rsp_valid = rsp_v_q;
        rsp_err   = rsp_e_q;
        rsp_rdata = (rsp_v_q && rd_ok_q) ? rd_shaped : '0;
        pio_en    = ctrl_q[1:0];
    end
endmodule

// File: rtl/pgwin_decoder_chk.sv
// Module: pgwin_decoder_chk
// Port-level protocol and legality checks for pgwin_decoder, bound below.
module pgwin_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [2:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic [1:0]  pio_en
);
    logic acc;
    logic bad_size;
    logic bad_align;

    // Request classification seen at the port.
    always_comb begin
        acc       = req_valid && req_ready;
        bad_size  = !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4);
        bad_align = (req_size == 3'd2 && req_addr[0]) ||
                    (req_size == 3'd4 && req_addr[1:0] != 2'b00);
    end

    p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);
    p_bad_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bad_size) |=> rsp_err);
    p_misalign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bad_align) |=> rsp_err);
    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));
    p_byte_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_size == 3'd1) |=> (rsp_rdata[31:8] == 24'h0));
    p_pio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && req_addr < 12'hC00 &&
         (req_addr[11:2] != 10'h202 || req_addr[1:0] != 2'b00)) |=> $stable(pio_en));
    p_pio_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && req_write) |=> $stable(pio_en));
endmodule

bind pgwin_decoder pgwin_decoder_chk u_chk (.*);

// File: tb/sim_pgwin_decoder.sv
// Directed bench for pgwin_decoder: one task per scenario, each self-checking.
module sim_pgwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  pio_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    pgwin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .pio_en(pio_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request: drive on a falling edge, sample on the next falling edge.
    task automatic access(input logic wr, input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        chk("R9 response valid", {31'h0, rsp_valid}, 32'h1);
        rd = rsp_rdata; er = rsp_err;
        req_valid = 1'b0;
    endtask

    task automatic wr_ok(input string req, input logic [11:0] a, input logic [2:0] sz,
                         input logic [31:0] wd);
        logic [31:0] rd; logic er;
        access(1'b1, a, sz, wd, rd, er);
        chk(req, {31'h0, er}, 32'h0);
    endtask

    task automatic rd_exp(input string req, input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] exp);
        logic [31:0] rd; logic er;
        access(1'b0, a, sz, 32'h0, rd, er);
        chk(req, {31'h0, er}, 32'h0);
        chk(req, rd, exp);
    endtask

    task automatic expect_err(input string req, input logic wr, input logic [11:0] a,
                              input logic [2:0] sz, input logic [31:0] wd);
        logic [31:0] rd; logic er;
        access(wr, a, sz, wd, rd, er);
        chk(req, {31'h0, er}, 32'h1);
        chk(req, rd, 32'h0);
    endtask

    task automatic set_page(input logic [5:0] p, input logic [1:0] en);
        wr_ok("R2 page write", 12'h808, 3'd4, (32'(p) << 13) | 32'(en));
    endtask

    task automatic t_reset;
        chk("R11 no response after reset", {31'h0, rsp_valid}, 32'h0);
        chk("R11 enables after reset", {30'h0, pio_en}, 32'h0);
        chk("R9 ready after reset", {31'h0, req_ready}, 32'h1);
        rd_exp("R11 control register after reset", 12'h808, 3'd4, 32'h0);
    endtask

    task automatic t_direct;
        wr_ok("R1 direct write", 12'h100, 3'd4, 32'hA5A5_1234);
        set_page(6'd5, 2'b00);
        rd_exp("R1 direct read ignores page", 12'h100, 3'd4, 32'hA5A5_1234);
        set_page(6'd0, 2'b00);
        rd_exp("R3 page 0 window at 0xD00", 12'hD00, 3'd4, 32'hA5A5_1234);
    endtask

    task automatic t_paged;
        set_page(6'd2, 2'b00);
        wr_ok("R3 page 2 write", 12'hC40, 3'd4, 32'h1111_2222);
        rd_exp("R3 page 2 lands on 0x840", 12'h840, 3'd4, 32'h1111_2222);
        rd_exp("R2 control via window 0xC08", 12'hC08, 3'd4, 32'h0000_4000);
        set_page(6'd3, 2'b00);
        wr_ok("R3 page 3 write", 12'hC40, 3'd4, 32'h3333_4444);
        set_page(6'd2, 2'b00);
        rd_exp("R3 page 2 kept apart from page 3", 12'hC40, 3'd4, 32'h1111_2222);
    endtask

    task automatic t_lanes;
        wr_ok("R7 clear word", 12'h200, 3'd4, 32'h0);
        wr_ok("R7 byte write", 12'h201, 3'd1, 32'h0000_00AB);
        rd_exp("R7 byte lane only", 12'h200, 3'd4, 32'h0000_AB00);
        wr_ok("R7 halfword write", 12'h202, 3'd2, 32'h0000_BEEF);
        rd_exp("R7 halfword lanes", 12'h200, 3'd4, 32'hBEEF_AB00);
        rd_exp("R7 byte read zero-extended", 12'h203, 3'd1, 32'h0000_00BE);
        rd_exp("R7 halfword read", 12'h200, 3'd2, 32'h0000_AB00);
    endtask

    task automatic t_size;
        expect_err("R4 size 3 write", 1'b1, 12'h200, 3'd3, 32'hFFFF_FFFF);
        expect_err("R4 size 0 read", 1'b0, 12'h200, 3'd0, 32'h0);
        expect_err("R4 size 7 write", 1'b1, 12'h200, 3'd7, 32'hFFFF_FFFF);
        rd_exp("R6 rejected writes left word intact", 12'h200, 3'd4, 32'hBEEF_AB00);
    endtask

    task automatic t_align;
        expect_err("R5 misaligned word write", 1'b1, 12'h202, 3'd4, 32'h1234_5678);
        expect_err("R5 misaligned halfword read", 1'b0, 12'h201, 3'd2, 32'h0);
        rd_exp("R6 misaligned write left word intact", 12'h200, 3'd4, 32'hBEEF_AB00);
    endtask

    task automatic t_pio;
        wr_ok("R8 enables set", 12'h808, 3'd4, 32'h0000_0003);
        @(negedge clk);
        chk("R8 enables follow bits 1:0", {30'h0, pio_en}, 32'h3);
        wr_ok("R8 halfword at 0x80A", 12'h80A, 3'd2, 32'h0000_0005);
        chk("R8 enables kept by halfword write", {30'h0, pio_en}, 32'h3);
        wr_ok("R8 byte at 0x809", 12'h809, 3'd1, 32'h0000_0040);
        chk("R8 enables kept by byte write", {30'h0, pio_en}, 32'h3);
        expect_err("R6 misaligned control write", 1'b1, 12'h809, 3'd4, 32'h0);
        chk("R6 enables kept by rejected write", {30'h0, pio_en}, 32'h3);
        rd_exp("R2 control contents", 12'h808, 3'd4, 32'h0005_4003);
        wr_ok("R8 byte 0 write", 12'h808, 3'd1, 32'h0000_0001);
        chk("R8 enables after byte 0 write", {30'h0, pio_en}, 32'h1);
    endtask

    task automatic t_unbacked;
        set_page(6'd0, 2'b00);
        wr_ok("R10 backed word", 12'h000, 3'd4, 32'h0000_0055);
        set_page(6'd4, 2'b00);
        wr_ok("R10 unbacked write no error", 12'hC00, 3'd4, 32'hDEAD_BEEF);
        rd_exp("R10 unbacked reads zero", 12'hC00, 3'd4, 32'h0);
        rd_exp("R10 backed word untouched", 12'h000, 3'd4, 32'h0000_0055);
    endtask

    task automatic t_b2b;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h808; req_size = 3'd4;
        req_wdata = 32'h0000_6000;   // page 3
        @(negedge clk);
        chk("R9 page write response", {30'h0, rsp_valid, rsp_err}, 32'h2);
        req_write = 1'b0; req_addr = 12'hC40;
        @(negedge clk);
        chk("R3 new page applies next cycle", rsp_rdata, 32'h3333_4444);
        chk("R9 read response", {30'h0, rsp_valid, rsp_err}, 32'h2);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 no response when idle", {31'h0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_direct;
        t_paged;
        t_lanes;
        t_size;
        t_align;
        t_pio;
        t_unbacked;
        t_b2b;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule